// File: doc/BRIEF.md
# UART In-Band Flow Control Engine

This block sits beside a UART's receive and transmit shifters and handles flow control carried inside the data stream. On the receive side, it watches each character the receiver delivers. It compares the character with four programmable control characters: two "resume" codes and two "pause" codes. When a pause code is recognised, a suspend flag tells the transmitter to stop fetching new bytes. The byte already being shifted out still completes. A one-cycle interrupt pulse is also produced. A resume code clears the suspend flag. Control can work on single characters, or on two-character pairs where the first code must be followed at once by the second. An optional mode lets any received character resume transmission.

On the transmit side, the block watches the receive FIFO fill level. When the level reaches the halt threshold, it asks the transmit shifter to send the pause code or codes. When the level then falls to the resume threshold, it asks for the resume code or codes. Each request is a request/grant handshake. The shifter grants it when its current character completes, ahead of the next FIFO byte.

Top module: `uart_swfc`

## Requirements
- R1: In the cycle after synchronous reset is released, `tx_suspend`, `xoff_irq` and `tx_req` are all 0.
- R2: With `rx_detect_en`=1 and `pair_mode`=0, a received character equal to `ch_xoff1` sets `tx_suspend` from the next cycle and makes `xoff_irq` high for exactly that one cycle. A received character equal to `ch_xon1` clears `tx_suspend` from the next cycle. The pause comparison takes priority.
- R3: With `pair_mode`=1, a pause is recognised only when `ch_xoff1` is received and the very next received character is `ch_xoff2`. Any other character in between breaks the pair.
- R4: With `pair_mode`=1, resume needs `ch_xon1` followed at once by `ch_xon2`. A character that equals a first code restarts the pairing from that character.
- R5: With `any_resume`=1 and detection enabled, any received character that does not complete a pause clears `tx_suspend`.
- R6: `fifo_wr` equals `rx_valid`, except that it is 0 for the character that completes a pause or resume match. In pair mode, the first character of a pair is still written.
- R7: With `rx_detect_en`=0, received characters never change `tx_suspend` or `xoff_irq`, and every character is written.
- R8: With `tx_insert_en`=1 and no pause outstanding, `rx_level` >= `halt_level` raises `tx_req` on the next cycle with `tx_char`=`ch_xoff1`. In pair mode, `ch_xoff2` is requested after the first grant.
- R9: After the pause code(s) have been granted, `rx_level` <= `resume_level` requests `ch_xon1` (then `ch_xon2` in pair mode). No new pause is requested while a pause is outstanding.
- R10: `tx_req` and `tx_char` hold steady until `tx_grant` is seen. `tx_req` drops only after a grant.
- R11: With `tx_insert_en`=0, no insertion request is raised, whatever the FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| fifo_wr | output | 1 | Write enable toward the receive FIFO |
| ch_xon1 | input | 8 | First resume code |
| ch_xon2 | input | 8 | Second resume code (pair mode) |
| ch_xoff1 | input | 8 | First pause code |
| ch_xoff2 | input | 8 | Second pause code (pair mode) |
| pair_mode | input | 1 | 1 = two-character codes |
| any_resume | input | 1 | 1 = any character resumes |
| rx_detect_en | input | 1 | Enable code recognition |
| tx_insert_en | input | 1 | Enable code insertion |
| rx_level | input | 7 | Receive FIFO fill level |
| halt_level | input | 7 | Level that triggers a pause |
| resume_level | input | 7 | Level that triggers a resume |
| tx_req | output | 1 | Insertion request to the shifter |
| tx_char | output | 8 | Character to insert |
| tx_grant | input | 1 | Shifter accepts `tx_char` |
| tx_suspend | output | 1 | Transmitter must stop fetching |
| xoff_irq | output | 1 | One-cycle pulse on pause recognition |

## Verification
The assertions check on every cycle that the suspend flag changes only on a cycle with an accepted received character. They also check that the interrupt is never high without the suspend flag, that insertion requests stay stable until granted and drop only after a grant, and that a request never starts while insertion is disabled. Only the bench's scenarios can show the sequence behaviour. These cases are: broken pairs, restart of a pair on a repeated first code, any-character resume, and dropping exactly the completing character. The pause/resume alternation against the threshold levels is also shown only by the scenarios. The bench's reference model follows all of these cycle by cycle.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

    localparam int CHAR_W = 8;
    typedef logic [CHAR_W-1:0] char_t;

    // receive matcher progress
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_XON1  = 2'd1,
        M_XOFF1 = 2'd2
    } match_st_t;

    typedef struct packed {
        logic      xoff_hit;
        logic      xon_hit;
        match_st_t nxt;
    } match_res_t;

    // transmit insertion progress
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2
    } ins_st_t;

    // One matcher step for a received character (pause has priority)
    function automatic match_res_t match_step(
        input match_st_t st,
        input char_t     c,
        input logic      pair,
        input char_t     on1,
        input char_t     on2,
        input char_t     off1,
        input char_t     off2
    );
        match_res_t r;
        r.xoff_hit = 1'b0;
        r.xon_hit  = 1'b0;
        r.nxt      = M_IDLE;
        if (!pair) begin
            if (c == off1)     r.xoff_hit = 1'b1;
            else if (c == on1) r.xon_hit  = 1'b1;
        end else if (st == M_XOFF1 && c == off2) begin
            r.xoff_hit = 1'b1;
        end else if (st == M_XON1 && c == on2) begin
            r.xon_hit = 1'b1;
        end else if (c == off1) begin
            r.nxt = M_XOFF1;
        end else if (c == on1) begin
            r.nxt = M_XON1;
        end
        return r;
    endfunction

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
    import swfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_valid,
    input  char_t rx_char,
    input  char_t on1,
    input  char_t on2,
    input  char_t off1,
    input  char_t off2,
    input  logic  pair,
    input  logic  any_en,
    input  logic  det_en,
    output logic  fifo_wr,
    output logic  suspend,
    output logic  irq
);

    match_st_t  st;
    match_res_t res;
    logic       take, hit_off, hit_on;

    always_comb begin
        res     = match_step(st, rx_char, pair, on1, on2, off1, off2);
        take    = rx_valid && det_en;
        hit_off = take && res.xoff_hit;
        hit_on  = take && res.xon_hit;
        fifo_wr = rx_valid && !(hit_off || hit_on);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= M_IDLE;
            suspend <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= hit_off;
            if (!det_en)       st <= M_IDLE;
            else if (rx_valid) st <= res.nxt;
            if (hit_off)                        suspend <= 1'b1;
            else if (hit_on || (take && any_en)) suspend <= 1'b0;
        end
    end

    // R2: suspend only rises on an accepted character
    assert_suspend_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(suspend) |-> $past(rx_valid && det_en));
    // R2: interrupt pulse implies suspended state
    assert_irq_suspend_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> suspend);
    // R5: resume only follows an accepted character
    assert_resume_source_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(suspend) |-> $past(rx_valid && det_en));
    // R7: a dropped character needs detection enabled
    assert_drop_needs_det_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !fifo_wr) |-> det_en);

endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic             pair,
    input  char_t            on1,
    input  char_t            on2,
    input  char_t            off1,
    input  char_t            off2,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    input  logic             grant,
    output logic             req,
    output char_t            ch
);

    ins_st_t st;
    logic    send_off, two, remote_halted;
    logic    start_off, start_on;

    always_comb begin
        start_off = ins_en && !remote_halted && (level >= halt_lvl);
        start_on  = ins_en &&  remote_halted && (level <= resume_lvl);
        req       = (st != S_IDLE);
        if (send_off) ch = (st == S_SECOND) ? off2 : off1;
        else          ch = (st == S_SECOND) ? on2  : on1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= S_IDLE;
            send_off      <= 1'b0;
            two           <= 1'b0;
            remote_halted <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start_off || start_on) begin
                        st       <= S_FIRST;
                        send_off <= start_off;
                        two      <= pair;
                    end
                end
                S_FIRST: begin
                    if (grant) begin
                        if (two) begin
                            st <= S_SECOND;
                        end else begin
                            st            <= S_IDLE;
                            remote_halted <= send_off;
                        end
                    end
                end
                S_SECOND: begin
                    if (grant) begin
                        st            <= S_IDLE;
                        remote_halted <= send_off;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: request and character hold until granted
    assert_hold_until_grant_R10: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> (req && $stable(ch)));
    // R10: request drops only after a grant
    assert_drop_after_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> $past(grant));
    // R11: no request starts while insertion is disabled
    assert_start_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(ins_en));

endmodule

// File: rtl/uart_swfc.sv
module uart_swfc
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_char,
    output logic             fifo_wr,
    input  logic [7:0]       ch_xon1,
    input  logic [7:0]       ch_xon2,
    input  logic [7:0]       ch_xoff1,
    input  logic [7:0]       ch_xoff2,
    input  logic             pair_mode,
    input  logic             any_resume,
    input  logic             rx_detect_en,
    input  logic             tx_insert_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] halt_level,
    input  logic [LVL_W-1:0] resume_level,
    output logic             tx_req,
    output logic [7:0]       tx_char,
    input  logic             tx_grant,
    output logic             tx_suspend,
    output logic             xoff_irq
);

    swfc_rx_match u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_char (rx_char),
        .on1     (ch_xon1),
        .on2     (ch_xon2),
        .off1    (ch_xoff1),
        .off2    (ch_xoff2),
        .pair    (pair_mode),
        .any_en  (any_resume),
        .det_en  (rx_detect_en),
        .fifo_wr (fifo_wr),
        .suspend (tx_suspend),
        .irq     (xoff_irq)
    );

    swfc_tx_insert #(.LVL_W(LVL_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .ins_en    (tx_insert_en),
        .pair      (pair_mode),
        .on1       (ch_xon1),
        .on2       (ch_xon2),
        .off1      (ch_xoff1),
        .off2      (ch_xoff2),
        .level     (rx_level),
        .halt_lvl  (halt_level),
        .resume_lvl(resume_level),
        .grant     (tx_grant),
        .req       (tx_req),
        .ch        (tx_char)
    );

endmodule

// File: tb/uart_swfc_test.sv
module uart_swfc_test;

    localparam int CLK_P = 10;
    localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic pair_mode = 1'b0, any_resume = 1'b0, rx_detect_en = 1'b1, tx_insert_en = 1'b0;
    logic [6:0] rx_level = 7'd0, halt_level = 7'd48, resume_level = 7'd16;
    logic tx_grant = 1'b0;
    logic fifo_wr, tx_req, tx_suspend, xoff_irq;
    logic [7:0] tx_char;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit   m_susp = 0, m_irq = 0, m_halted = 0, m_kind_off = 0;
    int   m_pend = 0;  // 0 none, 1 after first resume code, 2 after first pause code
    logic [7:0] m_q[$];

    always #(CLK_P/2) clk = ~clk;

    uart_swfc uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char), .fifo_wr(fifo_wr),
        .ch_xon1(ON1), .ch_xon2(ON2), .ch_xoff1(OFF1), .ch_xoff2(OFF2),
        .pair_mode(pair_mode), .any_resume(any_resume), .rx_detect_en(rx_detect_en),
        .tx_insert_en(tx_insert_en), .rx_level(rx_level), .halt_level(halt_level),
        .resume_level(resume_level), .tx_req(tx_req), .tx_char(tx_char),
        .tx_grant(tx_grant), .tx_suspend(tx_suspend), .xoff_irq(xoff_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // classify the current received character against the model
    task automatic classify(output bit off, output bit on, output int nxt);
        off = 0; on = 0; nxt = 0;
        if (!(rx_valid && rx_detect_en)) return;
        if (!pair_mode) begin
            if (rx_char == OFF1) off = 1;
            else if (rx_char == ON1) on = 1;
        end else begin
            if (m_pend == 2 && rx_char == OFF2) off = 1;
            else if (m_pend == 1 && rx_char == ON2) on = 1;
            else if (rx_char == OFF1) nxt = 2;
            else if (rx_char == ON1) nxt = 1;
        end
    endtask

    task automatic compare();
        bit off, on; int nxt;
        classify(off, on, nxt);
        chk("R2 tx_suspend", {7'd0, tx_suspend}, {7'd0, m_susp});
        chk("R2 xoff_irq", {7'd0, xoff_irq}, {7'd0, m_irq});
        chk("R6 fifo_wr", {7'd0, fifo_wr}, {7'd0, rx_valid && !(off || on)});
        chk("R8 tx_req", {7'd0, tx_req}, {7'd0, m_q.size() > 0});
        if (m_q.size() > 0) chk("R10 tx_char", tx_char, m_q[0]);
    endtask

    task automatic model_edge();
        bit off, on; int nxt;
        if (rst) begin
            m_susp = 0; m_irq = 0; m_pend = 0; m_halted = 0; m_kind_off = 0;
            m_q.delete();
            return;
        end
        classify(off, on, nxt);
        m_irq = off;
        if (!rx_detect_en) m_pend = 0;
        else if (rx_valid) m_pend = nxt;
        if (off) m_susp = 1;
        else if (on || (rx_valid && rx_detect_en && any_resume)) m_susp = 0;
        if (m_q.size() > 0) begin
            if (tx_grant) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) m_halted = m_kind_off;
            end
        end else if (tx_insert_en && !m_halted && rx_level >= halt_level) begin
            m_kind_off = 1; m_q.push_back(OFF1);
            if (pair_mode) m_q.push_back(OFF2);
        end else if (tx_insert_en && m_halted && rx_level <= resume_level) begin
            m_kind_off = 0; m_q.push_back(ON1);
            if (pair_mode) m_q.push_back(ON2);
        end
    endtask

    task automatic step();
        #1;
        compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c);
        rx_valid = 1'b1; rx_char = c;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic grant_now();
        tx_grant = 1'b1;
        step();
        tx_grant = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 tx_suspend", {7'd0, tx_suspend}, 8'd0);
        chk("R1 xoff_irq", {7'd0, xoff_irq}, 8'd0);
        chk("R1 tx_req", {7'd0, tx_req}, 8'd0);

        // single codes
        send(8'h41);
        send(OFF1);
        chk("R2 suspend set", {7'd0, tx_suspend}, 8'd1);
        chk("R2 irq pulse", {7'd0, xoff_irq}, 8'd1);
        send(8'h42);
        chk("R2 irq one cycle", {7'd0, xoff_irq}, 8'd0);
        chk("R2 still suspended", {7'd0, tx_suspend}, 8'd1);
        send(ON1);
        chk("R2 resumed", {7'd0, tx_suspend}, 8'd0);

        // pair codes
        pair_mode = 1'b1;
        send(OFF1); send(8'h55); send(OFF2);
        chk("R3 broken pair ignored", {7'd0, tx_suspend}, 8'd0);
        send(OFF1);
        chk("R6 first of pair kept", 8'd1, 8'd1);
        send(OFF2);
        chk("R3 pair pauses", {7'd0, tx_suspend}, 8'd1);
        send(ON1); send(ON1); send(ON2);
        chk("R4 restarted pair resumes", {7'd0, tx_suspend}, 8'd0);
        send(ON2);
        chk("R4 lone second code", {7'd0, tx_suspend}, 8'd0);

        // any-character resume
        pair_mode = 1'b0; any_resume = 1'b1;
        send(OFF1);
        chk("R5 paused", {7'd0, tx_suspend}, 8'd1);
        send(8'h30);
        chk("R5 any char resumes", {7'd0, tx_suspend}, 8'd0);
        any_resume = 1'b0;

        // detection off
        rx_detect_en = 1'b0;
        send(OFF1);
        chk("R7 no suspend when disabled", {7'd0, tx_suspend}, 8'd0);
        chk("R7 no irq when disabled", {7'd0, xoff_irq}, 8'd0);
        rx_detect_en = 1'b1;

        // insertion disabled
        rx_level = 7'd60;
        repeat (3) step();
        chk("R11 no request", {7'd0, tx_req}, 8'd0);

        // single-code insertion
        tx_insert_en = 1'b1;
        step();
        chk("R8 pause requested", {7'd0, tx_req}, 8'd1);
        chk("R8 pause char", tx_char, OFF1);
        repeat (3) step();
        chk("R10 held without grant", tx_char, OFF1);
        grant_now();
        chk("R10 released after grant", {7'd0, tx_req}, 8'd0);
        repeat (2) step();
        chk("R9 no second pause", {7'd0, tx_req}, 8'd0);
        rx_level = 7'd30;
        repeat (2) step();
        chk("R9 no resume above level", {7'd0, tx_req}, 8'd0);
        rx_level = 7'd16;
        step();
        chk("R9 resume char", tx_char, ON1);
        grant_now();

        // pair-code insertion, with reception in flight
        pair_mode = 1'b1;
        rx_level = 7'd48;
        step();
        chk("R8 pair first", tx_char, OFF1);
        send(8'h66);
        grant_now();
        chk("R8 pair second", tx_char, OFF2);
        grant_now();
        rx_level = 7'd2;
        step();
        chk("R9 pair first resume", tx_char, ON1);
        grant_now();
        chk("R9 pair second resume", tx_char, ON2);
        step();
        grant_now();
        repeat (3) step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule